// File: doc/BRIEF.md
# Array freeze and dump controller

This block wraps an on-die memory array, modelled as a single-port synchronous RAM, with test logic for silicon debug. In normal operation the array serves functional reads and writes. When a breakpoint or debug event raises the freeze input, the controller stops all further functional writes. The array's functional contents stay intact so that the state at the moment of the event can be examined.

While the array is frozen, a dump command walks the whole array in ascending address order. It reads each word through the shared read port and shifts the word out through a narrow lane, least significant lane first. A tester can present the expected lane value on every beat. Each beat that differs is flagged at once. A sticky failure flag and the address of the first failing word are held until reset. The freeze ends only when an unfreeze command arrives after a dump has completed.

Top module: `array_dump_ctrl`

## Requirements
- R1: While the array is not frozen and freeze_i is low, a write on an edge with fn_we_i high stores fn_wdata_i at fn_addr_i. A read on an edge with fn_re_i high, when no dump is running, gives fn_rvalid_o high with the stored word on fn_rdata_o in the following cycle.
- R2: A write presented in the same cycle as freeze_i, or in any cycle while frozen_o is high, leaves the array unchanged.
- R3: dump_start_i has no effect unless frozen_o is high and no dump is running. dump_valid_o stays low otherwise.
- R4: After an accepted start, each word takes one cycle with dump_valid_o low, then DATA_W/LANE_W cycles with dump_valid_o high. Addresses run from 0 to DEPTH-1. Beat b of a word carries bits [b*LANE_W +: LANE_W], starting with b = 0.
- R5: Functional reads are served while frozen when no dump runs. A read presented while a dump runs is dropped, and fn_rvalid_o stays low for it.
- R6: dump_mismatch_o is high in a beat exactly when dump_valid_o and cmp_en_i are high and dump_lane_o differs from exp_lane_i.
- R7: The first mismatching beat sets fail_o and loads fail_addr_o with that word's address. Both hold until reset, including across unfreeze and later dumps.
- R8: dump_done_o rises in the cycle after the last beat of address DEPTH-1. It holds until a new dump is accepted or the array is unfrozen.
- R9: unfreeze_i clears frozen_o only when dump_done_o is high and freeze_i is low. Otherwise it has no effect.
- R10: After reset, frozen_o, dump_valid_o, dump_done_o, fail_o and fn_rvalid_o are low and fail_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fn_we_i | input | 1 | Functional write strobe |
| fn_re_i | input | 1 | Functional read strobe |
| fn_addr_i | input | AW | Functional address |
| fn_wdata_i | input | DATA_W | Functional write data |
| fn_rdata_o | output | DATA_W | Functional read data |
| fn_rvalid_o | output | 1 | Read data valid, one cycle after the read |
| freeze_i | input | 1 | Debug-event freeze request |
| unfreeze_i | input | 1 | Release request, honoured after a completed dump |
| dump_start_i | input | 1 | Start a dump of the frozen array |
| cmp_en_i | input | 1 | Enable comparison of dumped beats |
| exp_lane_i | input | LANE_W | Expected lane value for the current beat |
| frozen_o | output | 1 | Array is frozen |
| dump_lane_o | output | LANE_W | Dumped lane data |
| dump_valid_o | output | 1 | dump_lane_o carries a beat |
| dump_mismatch_o | output | 1 | Current beat differs from expected |
| dump_done_o | output | 1 | Dump finished |
| fail_o | output | 1 | Sticky failure flag |
| fail_addr_o | output | AW | Address of the first failing word |

## Verification
The bench first targets the write that arrives in the same cycle as freeze_i. A design that samples the freeze only through its register would let that write corrupt the captured image. Each dump is checked beat by beat against the cadence and the lane order. This catches an address step that skips or repeats a word, and a reversed lane order. A functional read held high across the whole dump checks port priority: a design without priority would show a spurious fn_rvalid_o or disturb the dumped word. The bench also targets a second failing word, a later dump with new errors, and an unfreeze given before completion or together with freeze_i. A first-fail capture that is not sticky, or a release that is not gated, would show up as a changed fail_addr_o or a dropped frozen_o.

// File: rtl/afd_pkg.sv
package afd_pkg;
  typedef enum logic [1:0] {
    DS_IDLE,
    DS_READ,
    DS_SHIFT
  } dump_st_e;
endpackage

// File: rtl/afd_ram.sv
module afd_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // read-before-write; rdata only moves on a read
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/afd_dump_seq.sv
module afd_dump_seq
  import afd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANE_W = 2,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int BEATS = DATA_W / LANE_W,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clear_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              rd_o,
  output logic [AW-1:0]     addr_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              valid_o,
  output logic              done_o
);
  dump_st_e        state_q;
  logic [AW-1:0]   addr_q;
  logic [BW-1:0]   beat_q;
  logic            done_q;
  logic            last_beat;
  logic [LANE_W-1:0] lanes [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    assign lanes[g] = rdata_i[g*LANE_W +: LANE_W];
  end

  assign last_beat = (beat_q == BW'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DS_IDLE;
      addr_q  <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        DS_IDLE: begin
          if (start_i) begin
            state_q <= DS_READ;
            addr_q  <= '0;
            beat_q  <= '0;
            done_q  <= 1'b0;
          end else if (clear_done_i) begin
            done_q <= 1'b0;
          end
        end
        DS_READ: begin
          state_q <= DS_SHIFT;
          beat_q  <= '0;
        end
        DS_SHIFT: begin
          if (last_beat) begin
            if (addr_q == AW'(DEPTH - 1)) begin
              state_q <= DS_IDLE;
              done_q  <= 1'b1;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= DS_READ;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= DS_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != DS_IDLE);
  assign rd_o    = (state_q == DS_READ);
  assign valid_o = (state_q == DS_SHIFT);
  assign addr_o  = addr_q;
  assign lane_o  = lanes[beat_q];
  assign done_o  = done_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DS_READ && $past(state_q) == DS_SHIFT) |-> addr_q == $past(addr_q) + 1'b1); // R4
  AST_READ_BEFORE_BEATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(valid_o)) |-> $past(rd_o)); // R4
endmodule

// File: rtl/afd_cmp.sv
module afd_cmp #(
  parameter int LANE_W = 2,
  parameter int AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LANE_W-1:0] exp_i,
  input  logic [AW-1:0]     addr_i,
  output logic              miss_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o
);
  logic          fail_q;
  logic [AW-1:0] fail_addr_q;

  assign miss_o = beat_i && (lane_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (miss_o && !fail_q) begin
      fail_q      <= 1'b1;
      fail_addr_q <= addr_i;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> (fail_q && $stable(fail_addr_q))); // R7
endmodule

// File: rtl/array_dump_ctrl.sv
module array_dump_ctrl #(
  parameter int DATA_W = 8,
  parameter int LANE_W = 2,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fn_we_i,
  input  logic              fn_re_i,
  input  logic [AW-1:0]     fn_addr_i,
  input  logic [DATA_W-1:0] fn_wdata_i,
  output logic [DATA_W-1:0] fn_rdata_o,
  output logic              fn_rvalid_o,
  input  logic              freeze_i,
  input  logic              unfreeze_i,
  input  logic              dump_start_i,
  input  logic              cmp_en_i,
  input  logic [LANE_W-1:0] exp_lane_i,
  output logic              frozen_o,
  output logic [LANE_W-1:0] dump_lane_o,
  output logic              dump_valid_o,
  output logic              dump_mismatch_o,
  output logic              dump_done_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o
);
  logic              frozen_q;
  logic              rvalid_q;
  logic              seq_busy, seq_rd, seq_done;
  logic [AW-1:0]     seq_addr;
  logic              release_ok;
  logic              ram_we, ram_re;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_rdata;

  // freeze wins over a simultaneous release
  assign release_ok = unfreeze_i && seq_done && !freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      if (freeze_i)        frozen_q <= 1'b1;
      else if (release_ok) frozen_q <= 1'b0;
      rvalid_q <= fn_re_i && !seq_busy;
    end
  end

  // same-cycle freeze already blocks the write
  assign ram_we   = fn_we_i && !freeze_i && !frozen_q;
  assign ram_re   = seq_busy ? seq_rd : fn_re_i;
  assign ram_addr = seq_busy ? seq_addr : fn_addr_i;

  afd_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .addr_i  (ram_addr),
    .wdata_i (fn_wdata_i),
    .rdata_o (ram_rdata)
  );

  afd_dump_seq #(.DATA_W(DATA_W), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (dump_start_i && frozen_q),
    .clear_done_i (release_ok),
    .rdata_i      (ram_rdata),
    .busy_o       (seq_busy),
    .rd_o         (seq_rd),
    .addr_o       (seq_addr),
    .lane_o       (dump_lane_o),
    .valid_o      (dump_valid_o),
    .done_o       (seq_done)
  );

  afd_cmp #(.LANE_W(LANE_W), .AW(AW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_i      (dump_valid_o && cmp_en_i),
    .lane_i      (dump_lane_o),
    .exp_i       (exp_lane_i),
    .addr_i      (seq_addr),
    .miss_o      (dump_mismatch_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o)
  );

  assign fn_rdata_o  = ram_rdata;
  assign fn_rvalid_o = rvalid_q;
  assign frozen_o    = frozen_q;
  assign dump_done_o = seq_done;

  AST_VALID_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_valid_o |-> frozen_q); // R3
  AST_NO_WR_IN_DUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> !seq_busy); // R2
  AST_DONE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done |-> frozen_q); // R8
  AST_RELEASE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frozen_q) && !frozen_q) |-> $past(seq_done)); // R9
endmodule

// File: tb/array_dump_ctrl_tb.sv
`timescale 1ns/1ps
module array_dump_ctrl_tb;
  localparam int DATA_W = 8;
  localparam int LANE_W = 2;
  localparam int DEPTH  = 16;
  localparam int AW     = 4;
  localparam int BEATS  = DATA_W / LANE_W;
  localparam int WCYC   = BEATS + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fn_we = 0, fn_re = 0, freeze = 0, unfreeze = 0, dstart = 0, cmp_en = 0;
  logic [AW-1:0] fn_addr = '0;
  logic [DATA_W-1:0] fn_wdata = '0;
  logic [LANE_W-1:0] exp_lane = '0;
  logic [DATA_W-1:0] fn_rdata;
  logic fn_rvalid, frozen, dvalid, dmiss, ddone, fail;
  logic [LANE_W-1:0] dlane;
  logic [AW-1:0] fail_addr;

  int n_vec = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  array_dump_ctrl #(.DATA_W(DATA_W), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fn_we_i(fn_we), .fn_re_i(fn_re), .fn_addr_i(fn_addr), .fn_wdata_i(fn_wdata),
    .fn_rdata_o(fn_rdata), .fn_rvalid_o(fn_rvalid),
    .freeze_i(freeze), .unfreeze_i(unfreeze), .dump_start_i(dstart),
    .cmp_en_i(cmp_en), .exp_lane_i(exp_lane),
    .frozen_o(frozen), .dump_lane_o(dlane), .dump_valid_o(dvalid),
    .dump_mismatch_o(dmiss), .dump_done_o(ddone),
    .fail_o(fail), .fail_addr_o(fail_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    fn_we = 1; fn_addr = AW'(a); fn_wdata = DATA_W'(d);
    @(negedge clk);
    fn_we = 0;
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    fn_re = 1; fn_addr = AW'(a);
    @(negedge clk);
    #1;
    chk({req, " rvalid"}, int'(fn_rvalid), 1);
    chk({req, " rdata"}, int'(fn_rdata), int'(model[a]));
    fn_re = 0;
  endtask

  // bad_w: word with a corrupted expectation on beat 2; bad_v: on beat 0
  task automatic run_dump(input int bad_w, input int bad_v, input bit en);
    @(negedge clk);
    dstart = 1; cmp_en = en; fn_re = 1; fn_addr = '0;
    for (int i = 1; i <= DEPTH * WCYC + 1; i++) begin
      @(negedge clk);
      dstart = 0;
      if (i <= DEPTH * WCYC) begin
        automatic int w = (i - 1) / WCYC;
        automatic int b = ((i - 1) % WCYC) - 1;
        automatic bit corrupt = (w == bad_w && b == 2) || (w == bad_v && b == 0);
        automatic logic [LANE_W-1:0] e = (b >= 0) ? LANE_W'(model[w] >> (LANE_W * b)) : '0;
        exp_lane = corrupt ? e ^ 1'b1 : e;
        #1;
        chk("R4 valid cadence", int'(dvalid), int'(b >= 0));
        if (b >= 0) begin
          chk("R4 lane data", int'(dlane), int'(e));
          chk("R6 mismatch", int'(dmiss), int'(en && corrupt));
        end
        if (i == 1) chk("R8 done cleared on start", int'(ddone), 0);
      end else begin
        #1;
        chk("R8 done after last beat", int'(ddone), 1);
        chk("R4 valid low after dump", int'(dvalid), 0);
      end
      if (i >= 2) chk("R5 read dropped in dump", int'(fn_rvalid), 0);
    end
    fn_re = 0; cmp_en = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 frozen", int'(frozen), 0);
    chk("R10 valid", int'(dvalid), 0);
    chk("R10 done", int'(ddone), 0);
    chk("R10 fail", int'(fail), 0);
    chk("R10 fail_addr", int'(fail_addr), 0);
    chk("R10 rvalid", int'(fn_rvalid), 0);
    rst_ni = 1;

    for (int a = 0; a < DEPTH; a++) begin
      model[a] = DATA_W'(a * 37 + 5);
      wr(a, int'(model[a]));
    end
    for (int a = 0; a < DEPTH; a++) rd(a, "R1");

    // start while not frozen
    @(negedge clk); dstart = 1;
    @(negedge clk); dstart = 0;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R3 no dump unfrozen", int'(dvalid), 0);
    end

    // write together with freeze, then while frozen
    @(negedge clk);
    freeze = 1; fn_we = 1; fn_addr = 4'd3; fn_wdata = 8'hAA;
    @(negedge clk);
    freeze = 0; fn_addr = 4'd4; fn_wdata = 8'h55;
    #1; chk("R2 frozen set", int'(frozen), 1);
    @(negedge clk); fn_we = 0;
    rd(3, "R2 same-cycle write");
    rd(4, "R2 frozen write");
    rd(9, "R5 read while frozen");

    // release before any dump
    @(negedge clk); unfreeze = 1;
    @(negedge clk); unfreeze = 0; #1;
    chk("R9 early unfreeze", int'(frozen), 1);

    run_dump(5, 9, 1'b1);
    #1;
    chk("R7 fail", int'(fail), 1);
    chk("R7 first fail addr", int'(fail_addr), 5);

    @(negedge clk); unfreeze = 1;
    @(negedge clk); unfreeze = 0; #1;
    chk("R9 unfreeze after done", int'(frozen), 0);
    chk("R8 done cleared by unfreeze", int'(ddone), 0);
    chk("R7 fail kept", int'(fail), 1);

    model[7] = 8'hC3;
    wr(7, int'(model[7]));
    rd(7, "R1 write after release");

    @(negedge clk); freeze = 1;
    @(negedge clk); freeze = 0;
    run_dump(2, -1, 1'b1);
    #1;
    chk("R7 addr held", int'(fail_addr), 5);
    run_dump(7, 7, 1'b0);

    @(negedge clk); freeze = 1; unfreeze = 1;
    @(negedge clk); freeze = 0; unfreeze = 0; #1;
    chk("R9 freeze wins", int'(frozen), 1);
    chk("R8 done held", int'(ddone), 1);
    @(negedge clk); unfreeze = 1;
    @(negedge clk); unfreeze = 0; #1;
    chk("R9 release", int'(frozen), 0);
    chk("R7 fail addr after reruns", int'(fail_addr), 5);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule